// File: doc/BRIEF.md
# Double-Precision to Integer Converter with Saturation

This block turns one IEEE754 double-precision operand into an integer element. It truncates toward zero, narrows the result to a chosen destination width of 8, 16, 32 or 64 bits, and places it zero-extended on a 64-bit result bus. The caller chooses whether the conversion is signed or unsigned. Separately, the caller chooses a saturation override: none, signed or unsigned. The block treats the truncated value as an exact integer of unlimited precision. It then limits that value to the intersection of the range implied by the conversion's signedness and the range implied by the saturation override. With no override, the result wraps modulo the destination width instead of clamping.

A two-state output controller holds the valid indication. In state ST_EMPTY, an accepted operand (in_valid high) takes the ACCEPT transition to ST_FULL. In state ST_FULL, a further operand takes the STREAM transition and stays in ST_FULL, and an idle cycle takes the DRAIN transition back to ST_EMPTY. An idle cycle in ST_EMPTY keeps the state in ST_EMPTY (IDLE). The result and the saturation flag are registered and change only when an operand is accepted.

Top module: `fcvt_sat_top`

## Requirements
- R1: out_valid equals in_valid delayed by exactly one clock. out_result and out_sat update only on a clock where in_valid is high, and hold their values otherwise.
- R2: Width code 0/1/2/3 selects 8/16/32/64 bits. Saturation code 0 is wrap, 1 is the signed cap and 2 is the unsigned floor. Code 3 behaves as wrap. Result bits at and above the selected width are always zero.
- R3: Fractional bits are discarded, so rounding is toward zero. Every finite operand with magnitude below 1.0 yields 0 with the flag clear. This covers both zeros and subnormals.
- R4: In wrap mode, the result is the low W bits of the two's complement of the truncated integer, so it is congruent to that integer modulo 2^W. The result is the same for both signedness settings, and out_sat is 0.
- R5: In wrap mode, NaN and both infinities yield 0 with the flag clear.
- R6: With saturation enabled, the lower limit is 0 if the conversion is unsigned or the override is unsigned, and -2^(W-1) otherwise. The upper limit is 2^(W-1)-1 if the conversion is signed or the override is signed, and 2^W-1 otherwise. A value outside the range is replaced by the nearer limit, written as W-bit two's complement.
- R7: An unsigned conversion with the signed override and a 16-bit width always gives a result in 0..0x7FFF.
- R8: With saturation enabled, out_sat is 1 exactly when the exact value lay outside the range. A value inside the range is delivered exactly.
- R9: With saturation enabled, NaN yields 0 with the flag set. +Inf gives the upper limit and -Inf gives the lower limit, each with the flag set.
- R10: At the edges, 0x43DFFFFFFFFFFFFF converts (signed, 64-bit) to 0x7FFFFFFFFFFFFC00 unclamped, and 2^63 clamps. 0x43EFFFFFFFFFFFFF converts (unsigned, 64-bit) unclamped, and 2^64 clamps. 0x41DFFFFFFFC00000 gives 0x7FFFFFFF (signed, 32-bit) and 0x41EFFFFFFFE00000 gives 0xFFFFFFFF (unsigned, 32-bit), both unclamped.
- R11: While reset is asserted and after its release, out_valid, out_result and out_sat are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Double-precision operand bits |
| in_width | input | 2 | Destination width code |
| in_signed | input | 1 | 1 = signed conversion, 0 = unsigned |
| in_sat | input | 2 | Saturation override code |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_result | output | 64 | Converted element, zero-extended |
| out_sat | output | 1 | Clamping or invalid-operand indication |

## Verification
The assertions assume that in_width, in_signed, in_sat and in_operand carry known values whenever in_valid is high. They also assume these inputs are sampled only at that clock's rising edge. The bench keeps to this by changing every input on the falling edge and holding it for a full period. It drives no X and keeps in_valid low around reset. Mode code 3 is the one reserved encoding, and it is driven deliberately to confirm that it behaves as wrap.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elw_e;

    typedef enum logic [1:0] {
        SM_WRAP   = 2'd0,
        SM_SCAP   = 2'd1,
        SM_UFLOOR = 2'd2,
        SM_RSVD   = 2'd3
    } satm_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ost_e;

    function automatic int elw_bits(elw_e w);
        return 8 << w;
    endfunction

    function automatic logic sat_enabled(satm_e m);
        return (m == SM_SCAP) || (m == SM_UFLOOR);
    endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack #(
    parameter int FP_W   = 64,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic [FP_W-1:0]  op,
    output logic             neg,
    output logic             is_nan,
    output logic             is_inf,
    output logic             huge,
    output logic [INT_W-1:0] mag
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W = FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;
    logic [SIG_W-1:0]  sig;
    logic              exp_top;
    int                k;

    always_comb begin
        neg     = op[FP_W-1];
        exp_f   = op[FP_W-2 -: EXP_W];
        frac    = op[FRAC_W-1:0];
        sig     = {1'b1, frac};
        exp_top = &exp_f;
        is_nan  = exp_top && (|frac);
        is_inf  = exp_top && !(|frac);
        k       = int'(exp_f) - BIAS;
        mag     = '0;
        huge    = 1'b0;
        if (!exp_top && k >= 0) begin
            huge = (k >= INT_W);
            if (k <= FRAC_W) begin
                mag = INT_W'(sig >> 32'(FRAC_W - k));
            end else if ((k - FRAC_W) < INT_W) begin
                mag = INT_W'(sig) << 32'(k - FRAC_W);
            end
        end
    end

endmodule

// File: rtl/fcvt_limits.sv
module fcvt_limits
    import fcvt_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  elw_e                     width,
    input  logic                     conv_signed,
    input  satm_e                    mode,
    output logic signed [INT_W+1:0]  lo,
    output logic signed [INT_W+1:0]  hi,
    output logic        [INT_W-1:0]  mask
);
    localparam int WIDE = INT_W + 2;

    logic signed [WIDE-1:0] one;
    logic signed [WIDE-1:0] span;
    logic signed [WIDE-1:0] half;
    logic                   floor_zero;
    logic                   cap_signed;
    int                     bits;

    always_comb begin
        bits       = elw_bits(width);
        one        = WIDE'(1);
        span       = one << bits;
        half       = one << (bits - 1);
        mask       = INT_W'(span - one);
        floor_zero = !conv_signed || (mode == SM_UFLOOR);
        cap_signed = conv_signed || (mode == SM_SCAP);
        lo         = floor_zero ? '0 : -half;
        hi         = cap_signed ? (half - one) : (span - one);
    end

endmodule

// File: rtl/fcvt_clamp.sv
module fcvt_clamp
    import fcvt_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0]         mag,
    input  logic                     huge,
    input  logic                     neg,
    input  logic                     is_nan,
    input  logic                     is_inf,
    input  satm_e                    mode,
    input  logic signed [INT_W+1:0]  lo,
    input  logic signed [INT_W+1:0]  hi,
    input  logic [INT_W-1:0]         mask,
    output logic [INT_W-1:0]         res,
    output logic                     flag
);
    localparam int WIDE = INT_W + 2;

    logic signed [WIDE-1:0] exact;
    logic [INT_W-1:0]       lo_bits;
    logic [INT_W-1:0]       hi_bits;

    always_comb begin
        exact   = neg ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
        lo_bits = INT_W'(lo) & mask;
        hi_bits = INT_W'(hi) & mask;
        res     = '0;
        flag    = 1'b0;
        if (!sat_enabled(mode)) begin
            if (!is_nan && !is_inf) begin
                res = exact[INT_W-1:0] & mask;
            end
        end else if (is_nan) begin
            flag = 1'b1;
        end else if (is_inf || huge) begin
            res  = neg ? lo_bits : hi_bits;
            flag = 1'b1;
        end else if (exact > hi) begin
            res  = hi_bits;
            flag = 1'b1;
        end else if (exact < lo) begin
            res  = lo_bits;
            flag = 1'b1;
        end else begin
            res = exact[INT_W-1:0] & mask;
        end
    end

endmodule

// File: rtl/fcvt_sat_top.sv
module fcvt_sat_top
    import fcvt_pkg::*;
#(
    parameter int FP_W   = 64,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    input  logic [1:0]       in_width,
    input  logic             in_signed,
    input  logic [1:0]       in_sat,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_sat
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    elw_e                   width_c;
    satm_e                  mode_c;
    logic                   u_neg, u_nan, u_inf, u_huge;
    logic [INT_W-1:0]       u_mag;
    logic signed [INT_W+1:0] lim_lo, lim_hi;
    logic [INT_W-1:0]       lim_mask;
    logic [INT_W-1:0]       c_res;
    logic                   c_flag;
    ost_e                   state, state_nx;
    logic [INT_W-1:0]       res_q;
    logic                   flag_q;

    assign width_c = elw_e'(in_width);
    assign mode_c  = satm_e'(in_sat);

    fcvt_unpack #(.FP_W(FP_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
        .op(in_operand), .neg(u_neg), .is_nan(u_nan), .is_inf(u_inf),
        .huge(u_huge), .mag(u_mag)
    );

    fcvt_limits #(.INT_W(INT_W)) u_limits (
        .width(width_c), .conv_signed(in_signed), .mode(mode_c),
        .lo(lim_lo), .hi(lim_hi), .mask(lim_mask)
    );

    fcvt_clamp #(.INT_W(INT_W)) u_clamp (
        .mag(u_mag), .huge(u_huge), .neg(u_neg), .is_nan(u_nan), .is_inf(u_inf),
        .mode(mode_c), .lo(lim_lo), .hi(lim_hi), .mask(lim_mask),
        .res(c_res), .flag(c_flag)
    );

    // Transitions: IDLE (empty->empty), ACCEPT (empty->full),
    // STREAM (full->full), DRAIN (full->empty)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            res_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_valid) begin
                res_q  <= c_res;
                flag_q <= c_flag;
            end
        end
    end

    always_comb begin
        out_valid  = (state == ST_FULL);
        out_result = res_q;
        out_sat    = flag_q;
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_sat)));
    assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_result & ~$past(lim_mask)) == '0));
    assert_below_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_operand[FP_W-2 -: EXP_W] < EXP_W'(BIAS)))
        |=> (out_result == '0 && !out_sat));
    assert_wrap_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_enabled(mode_c)) |=> !out_sat);
    assert_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && mode_c == SM_SCAP && width_c == EW_16)
        |=> (out_result <= INT_W'(16'h7FFF)));
    assert_nan_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_enabled(mode_c) && u_nan) |=> (out_result == '0 && out_sat));

endmodule

// File: tb/tb_fcvt_sat_top.sv
`timescale 1ns/1ps
module tb_fcvt_sat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_width = '0;
    logic        in_signed = 1'b0;
    logic [1:0]  in_sat = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fcvt_sat_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_width(in_width), .in_signed(in_signed), .in_sat(in_sat),
        .out_valid(out_valid), .out_result(out_result), .out_sat(out_sat)
    );

    // {operand, width, signed, sat mode, expected result, expected flag, requirement}
    localparam int NV = 33;
    localparam logic [137:0] VEC [NV] = '{
        {64'h4004000000000000, 2'd2, 1'b1, 2'd0, 64'h0000000000000002, 1'b0, 4'd3},  // R3
        {64'hC004000000000000, 2'd2, 1'b1, 2'd0, 64'h00000000FFFFFFFE, 1'b0, 4'd4},  // R4
        {64'hC004000000000000, 2'd2, 1'b0, 2'd0, 64'h00000000FFFFFFFE, 1'b0, 4'd4},  // R4
        {64'h3FE8000000000000, 2'd3, 1'b1, 2'd1, 64'h0000000000000000, 1'b0, 4'd3},  // R3
        {64'h4072C00000000000, 2'd0, 1'b1, 2'd0, 64'h000000000000002C, 1'b0, 4'd4},  // R4
        {64'hC072C00000000000, 2'd0, 1'b0, 2'd0, 64'h00000000000000D4, 1'b0, 4'd4},  // R4
        {64'h4072C00000000000, 2'd0, 1'b1, 2'd1, 64'h000000000000007F, 1'b1, 4'd6},  // R6
        {64'hC072C00000000000, 2'd0, 1'b1, 2'd1, 64'h0000000000000080, 1'b1, 4'd6},  // R6
        {64'hC072C00000000000, 2'd0, 1'b0, 2'd1, 64'h0000000000000000, 1'b1, 4'd6},  // R6
        {64'h4072C00000000000, 2'd0, 1'b0, 2'd2, 64'h00000000000000FF, 1'b1, 4'd6},  // R6
        {64'h4059000000000000, 2'd0, 1'b1, 2'd2, 64'h0000000000000064, 1'b0, 4'd8},  // R8
        {64'h40E3880000000000, 2'd1, 1'b0, 2'd1, 64'h0000000000007FFF, 1'b1, 4'd7},  // R7
        {64'h40E3880000000000, 2'd1, 1'b0, 2'd2, 64'h0000000000009C40, 1'b0, 4'd8},  // R8
        {64'hC004000000000000, 2'd1, 1'b0, 2'd1, 64'h0000000000000000, 1'b1, 4'd7},  // R7
        {64'h7FF8000000000000, 2'd2, 1'b1, 2'd1, 64'h0000000000000000, 1'b1, 4'd9},  // R9
        {64'h7FF8000000000000, 2'd2, 1'b1, 2'd0, 64'h0000000000000000, 1'b0, 4'd5},  // R5
        {64'h7FF0000000000000, 2'd3, 1'b0, 2'd2, 64'hFFFFFFFFFFFFFFFF, 1'b1, 4'd9},  // R9
        {64'hFFF0000000000000, 2'd1, 1'b1, 2'd1, 64'h0000000000008000, 1'b1, 4'd9},  // R9
        {64'h7FF0000000000000, 2'd1, 1'b1, 2'd0, 64'h0000000000000000, 1'b0, 4'd5},  // R5
        {64'h43DFFFFFFFFFFFFF, 2'd3, 1'b1, 2'd1, 64'h7FFFFFFFFFFFFC00, 1'b0, 4'd10}, // R10
        {64'h43E0000000000000, 2'd3, 1'b1, 2'd1, 64'h7FFFFFFFFFFFFFFF, 1'b1, 4'd10}, // R10
        {64'h43EFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd2, 64'hFFFFFFFFFFFFF800, 1'b0, 4'd10}, // R10
        {64'h43F0000000000000, 2'd3, 1'b0, 2'd2, 64'hFFFFFFFFFFFFFFFF, 1'b1, 4'd10}, // R10
        {64'h41DFFFFFFFC00000, 2'd2, 1'b1, 2'd1, 64'h000000007FFFFFFF, 1'b0, 4'd10}, // R10
        {64'h41EFFFFFFFE00000, 2'd2, 1'b0, 2'd2, 64'h00000000FFFFFFFF, 1'b0, 4'd10}, // R10
        {64'h41E0000000000000, 2'd2, 1'b1, 2'd1, 64'h000000007FFFFFFF, 1'b1, 4'd10}, // R10
        {64'h43E0000000000000, 2'd3, 1'b1, 2'd0, 64'h8000000000000000, 1'b0, 4'd4},  // R4
        {64'h4450000000000000, 2'd2, 1'b0, 2'd1, 64'h000000007FFFFFFF, 1'b1, 4'd6},  // R6
        {64'h0000000000000001, 2'd0, 1'b1, 2'd1, 64'h0000000000000000, 1'b0, 4'd3},  // R3
        {64'h8000000000000000, 2'd2, 1'b1, 2'd2, 64'h0000000000000000, 1'b0, 4'd3},  // R3
        {64'hBFF0000000000000, 2'd3, 1'b1, 2'd1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 4'd6},  // R6
        {64'h4072C00000000000, 2'd0, 1'b1, 2'd3, 64'h000000000000002C, 1'b0, 4'd2},  // R2
        {64'hC072C00000000000, 2'd1, 1'b1, 2'd1, 64'h000000000000FED4, 1'b0, 4'd6}   // R6
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R11: state during reset
        check(out_valid == 1'b0 && out_result == '0 && out_sat == 1'b0, "R11",
              out_result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == '0 && out_sat == 1'b0, "R11",
              {63'b0, out_valid}, 64'h0);

        // Vector walk, back-to-back operands
        for (int i = 0; i < NV; i++) begin
            in_operand = VEC[i][137:74];
            in_width   = VEC[i][73:72];
            in_signed  = VEC[i][71];
            in_sat     = VEC[i][70:69];
            in_valid   = 1'b1;
            @(negedge clk);
            check(out_result == VEC[i][68:5], $sformatf("R%0d vec %0d result", VEC[i][3:0], i),
                  out_result, VEC[i][68:5]);
            check(out_sat == VEC[i][4], $sformatf("R%0d vec %0d flag", VEC[i][3:0], i),
                  {63'b0, out_sat}, {63'b0, VEC[i][4]});
            check(out_valid == 1'b1, "R1 valid during stream", {63'b0, out_valid}, 64'h1);
        end

        // R1: idle cycle drops valid and holds the last result, even with new operand
        held       = out_result;
        in_valid   = 1'b0;
        in_operand = 64'h4059000000000000;
        in_width   = 2'd3;
        in_sat     = 2'd0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 drain", {63'b0, out_valid}, 64'h0);
        check(out_result == held && out_sat == 1'b0, "R1 hold", out_result, held);
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == held, "R1 idle", out_result, held);

        // R1: single accepted operand after a gap
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && out_result == 64'd100, "R1 accept", out_result, 64'd100);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 single pulse", {63'b0, out_valid}, 64'h0);

        // R11: reset in mid-run clears outputs
        in_valid   = 1'b1;
        in_operand = 64'h7FF0000000000000;
        in_sat     = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == '0 && out_sat == 1'b0, "R11 reapply",
              out_result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule